// File: doc/BRIEF.md
# Associative Translation Cache with Front Promotion

The block keeps a small, fully associative set of address translations in a priority-ordered array of slots. A lookup compares a virtual address together with its address-space id, virtual-machine id, hypervisor flag and security state against every slot in parallel. It reports whether a slot hit, which slot it was, the physical address and the hit entry's exception level and global flag, all in the same cycle.

Refills always enter at slot 0 and push the rest of the array one slot down, so the last slot falls out. A hit found deeper than a one-slot recently-used window is rotated to slot 0. Debug lookups leave the order untouched. Maintenance requests remove entries in two ways. Whole-security-state and address-space-id requests clear in a single cycle. Per-address requests walk the array and clear one matching slot per cycle, with lookups stalled while the walk runs. Saturating counters track hits, misses, refills and removed entries.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is invalid, all four counters read zero and `busy_o` is low.
- R2: A slot matches a lookup when it is valid and all of the following hold: its page number equals the upper bits of `lk_va_i`, its VMID equals `lk_vmid_i`, its hyp flag equals `lk_hyp_i`, and its non-secure tag equals the inverse of `lk_secure_i`. Its ASID must also equal `lk_asid_i` unless the entry is global. On a hit, `lk_pa_o` is the entry's frame number joined to the low `OFF_W` bits of the virtual address, in the same cycle.
- R3: Slots are searched from slot 0 upward and the lowest matching slot is reported.
- R4: An accepted refill writes the new valid entry into slot 0 and moves each slot i to slot i+1. The former last slot is discarded.
- R5: A non-debug hit at a slot index above `MRU_WIN` (1 by default) moves that entry to slot 0. Each entry below it moves down one slot. Entries above it stay where they are.
- R6: A hit at slot 0 or 1 leaves the order unchanged. A lookup with `lk_debug_i` high never reorders and is not counted.
- R7: `inv_kind_i`=0 (all) clears every valid entry whose non-secure tag is the inverse of `inv_secure_i`. The entry's VMID must also equal `inv_vmid_i`, unless `inv_secure_i` is high.
- R8: `inv_kind_i`=1 (by ASID) applies the R7 conditions and additionally requires the entry ASID to equal `inv_asid_i`.
- R9: `inv_kind_i`=2 (address with ASID) and 3 (address, any ASID) start a walk. Each cycle the walk clears the lowest slot that matches `inv_vpn_i`, VMID and hyp, and whose non-secure tag agrees with `inv_secure_i`. Kind 2 also requires a matching ASID or a global entry. With k matching slots, `busy_o` stays high for k+1 cycles.
- R10: While `busy_o` is high, lookups report no hit, and refills and maintenance requests are ignored.
- R11: In one cycle a maintenance request takes priority over a refill, and a refill over a lookup. A lookup that is not accepted reports no hit.
- R12: The hit, miss, refill and cleared-entry counters are `CNT_W` bits wide (32 by default) and saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | VPN_W+OFF_W | Lookup virtual address |
| lk_asid_i | input | ASID_W | Lookup address-space id |
| lk_vmid_i | input | VMID_W | Lookup VM id |
| lk_hyp_i | input | 1 | Lookup hypervisor context |
| lk_secure_i | input | 1 | Lookup secure state |
| lk_debug_i | input | 1 | Non-intrusive lookup |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Hit slot index |
| lk_pa_o | output | PFN_W+OFF_W | Physical address |
| lk_el_o | output | EL_W | Hit entry exception level |
| lk_global_o | output | 1 | Hit entry global flag |
| fill_i | input | 1 | Refill request |
| fill_vpn_i | input | VPN_W | Refill page number |
| fill_pfn_i | input | PFN_W | Refill frame number |
| fill_asid_i | input | ASID_W | Refill ASID |
| fill_vmid_i | input | VMID_W | Refill VMID |
| fill_ns_i | input | 1 | Refill non-secure tag |
| fill_hyp_i | input | 1 | Refill hyp flag |
| fill_global_i | input | 1 | Refill global flag |
| fill_el_i | input | EL_W | Refill exception level |
| inv_req_i | input | 1 | Maintenance request |
| inv_kind_i | input | 2 | 0 all, 1 ASID, 2 address+ASID, 3 address |
| inv_secure_i | input | 1 | Targeted security state |
| inv_vmid_i | input | VMID_W | Current VMID |
| inv_asid_i | input | ASID_W | Targeted ASID |
| inv_vpn_i | input | VPN_W | Targeted page number |
| inv_hyp_i | input | 1 | Targeted hyp context |
| busy_o | output | 1 | Address walk in progress |
| hit_cnt_o | output | CNT_W | Hit counter |
| miss_cnt_o | output | CNT_W | Miss counter |
| fill_cnt_o | output | CNT_W | Refill counter |
| flush_cnt_o | output | CNT_W | Cleared-entry counter |

## Verification
Lookups are tried against several array states. Duplicate translations separate the lowest-slot rule from newest-entry assumptions. Hits at slot 1 versus slot 2 separate the window from eager promotion, and debug versus normal hits at slot 2 show that only the latter reorder. Lookups that differ from a stored entry in a single field (ASID on global and non-global entries, security, VMID, hyp) show that each field takes part in the match. Maintenance runs over mixed populations of security tag, VMID and ASID, so that each clearing condition is seen both to remove and to keep an entry. The address walk is timed by its busy length.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    INV_ALL    = 2'd0,
    INV_ASID   = 2'd1,
    INV_VA     = 2'd2,
    INV_VA_ANY = 2'd3
  } inv_kind_e;
endpackage

// File: rtl/xlate_first.sv
module xlate_first #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xlate_satcnt.sv
module xlate_satcnt #(
  parameter int W  = 32,
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  cnt_o
);
  localparam int SW = ((W > IW) ? W : IW) + 1;
  localparam logic [SW-1:0] MAX = SW'({W{1'b1}});

  logic [SW-1:0] sum;
  assign sum = SW'(cnt_o) + SW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= (sum > MAX) ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VPN_W     = 20,
  parameter int PFN_W     = 20,
  parameter int OFF_W     = 12,
  parameter int ASID_W    = 8,
  parameter int VMID_W    = 8,
  parameter int EL_W      = 2,
  parameter int MRU_WIN   = 1,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int VA_W     = VPN_W + OFF_W,
  localparam int PA_W     = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  logic              lk_hyp_i,
  input  logic              lk_secure_i,
  input  logic              lk_debug_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [EL_W-1:0]   lk_el_o,
  output logic              lk_global_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              fill_ns_i,
  input  logic              fill_hyp_i,
  input  logic              fill_global_i,
  input  logic [EL_W-1:0]   fill_el_i,
  input  logic              inv_req_i,
  input  logic [1:0]        inv_kind_i,
  input  logic              inv_secure_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic              inv_hyp_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  fill_cnt_o,
  output logic [CNT_W-1:0]  flush_cnt_o
);
  localparam int CI_W = $clog2(N_ENTRIES + 1);

  typedef struct packed {
    logic              v;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              ns;
    logic              hyp;
    logic              glob;
    logic [EL_W-1:0]   el;
  } ent_t;

  ent_t ent_q [N_ENTRIES];

  // walk state
  logic              va_busy_q;
  logic [VPN_W-1:0]  iv_vpn_q;
  logic [ASID_W-1:0] iv_asid_q;
  logic [VMID_W-1:0] iv_vmid_q;
  logic              iv_hyp_q, iv_sec_q, iv_any_q;

  logic [VPN_W-1:0]     lk_vpn;
  logic [N_ENTRIES-1:0] lk_match, va_match, bulk_match;
  logic                 lk_found, va_found;
  logic [IDX_W-1:0]     lk_idx, va_idx;
  logic                 lk_acc, fill_acc, inv_acc, bulk_en, walk_start, promote;
  inv_kind_e            kind;
  ent_t                 fill_ent;

  assign kind       = inv_kind_e'(inv_kind_i);
  assign busy_o     = va_busy_q;
  assign inv_acc    = inv_req_i && !va_busy_q;
  assign bulk_en    = inv_acc && (kind == INV_ALL || kind == INV_ASID);
  assign walk_start = inv_acc && (kind == INV_VA || kind == INV_VA_ANY);
  assign fill_acc   = fill_i && !va_busy_q && !inv_req_i;
  assign lk_acc     = lk_valid_i && !va_busy_q && !inv_req_i && !fill_i;
  assign lk_vpn     = lk_va_i[VA_W-1:OFF_W];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = ent_q[g].v && ent_q[g].vpn == lk_vpn &&
                         ent_q[g].vmid == lk_vmid_i && ent_q[g].hyp == lk_hyp_i &&
                         ent_q[g].ns == !lk_secure_i &&
                         (ent_q[g].glob || ent_q[g].asid == lk_asid_i);
    assign va_match[g] = ent_q[g].v && ent_q[g].vpn == iv_vpn_q &&
                         ent_q[g].vmid == iv_vmid_q && ent_q[g].hyp == iv_hyp_q &&
                         ent_q[g].ns == !iv_sec_q &&
                         (iv_any_q || ent_q[g].glob || ent_q[g].asid == iv_asid_q);
    assign bulk_match[g] = ent_q[g].v && ent_q[g].ns == !inv_secure_i &&
                           (inv_secure_i || ent_q[g].vmid == inv_vmid_i) &&
                           (kind == INV_ALL || ent_q[g].asid == inv_asid_i);
  end

  xlate_first #(.N(N_ENTRIES), .IW(IDX_W)) u_lk_sel (
    .req_i(lk_match), .found_o(lk_found), .idx_o(lk_idx)
  );
  xlate_first #(.N(N_ENTRIES), .IW(IDX_W)) u_va_sel (
    .req_i(va_match), .found_o(va_found), .idx_o(va_idx)
  );

  assign lk_hit_o    = lk_acc && lk_found;
  assign lk_idx_o    = lk_idx;
  assign lk_pa_o     = {ent_q[lk_idx].pfn, lk_va_i[OFF_W-1:0]};
  assign lk_el_o     = ent_q[lk_idx].el;
  assign lk_global_o = ent_q[lk_idx].glob;
  assign promote     = lk_hit_o && !lk_debug_i && (int'(lk_idx) > MRU_WIN);

  always_comb begin
    fill_ent      = '0;
    fill_ent.v    = 1'b1;
    fill_ent.vpn  = fill_vpn_i;
    fill_ent.pfn  = fill_pfn_i;
    fill_ent.asid = fill_asid_i;
    fill_ent.vmid = fill_vmid_i;
    fill_ent.ns   = fill_ns_i;
    fill_ent.hyp  = fill_hyp_i;
    fill_ent.glob = fill_global_i;
    fill_ent.el   = fill_el_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
    end else if (bulk_en) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (bulk_match[i]) ent_q[i].v <= 1'b0;
    end else if (va_busy_q) begin
      if (va_found) ent_q[va_idx].v <= 1'b0;
    end else if (fill_acc) begin
      ent_q[0] <= fill_ent;
      for (int i = 1; i < N_ENTRIES; i++) ent_q[i] <= ent_q[i-1];
    end else if (promote) begin
      ent_q[0] <= ent_q[lk_idx];
      for (int i = 1; i < N_ENTRIES; i++)
        if (i <= int'(lk_idx)) ent_q[i] <= ent_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_busy_q <= 1'b0;
      iv_vpn_q  <= '0;
      iv_asid_q <= '0;
      iv_vmid_q <= '0;
      iv_hyp_q  <= 1'b0;
      iv_sec_q  <= 1'b0;
      iv_any_q  <= 1'b0;
    end else if (walk_start) begin
      va_busy_q <= 1'b1;
      iv_vpn_q  <= inv_vpn_i;
      iv_asid_q <= inv_asid_i;
      iv_vmid_q <= inv_vmid_i;
      iv_hyp_q  <= inv_hyp_i;
      iv_sec_q  <= inv_secure_i;
      iv_any_q  <= (kind == INV_VA_ANY);
    end else if (va_busy_q && !va_found) begin
      va_busy_q <= 1'b0;
    end
  end

  logic [CI_W-1:0] hit_inc, miss_inc, fill_inc, flush_inc;
  assign hit_inc   = CI_W'(lk_hit_o && !lk_debug_i);
  assign miss_inc  = CI_W'(lk_acc && !lk_found && !lk_debug_i);
  assign fill_inc  = CI_W'(fill_acc);
  assign flush_inc = bulk_en ? CI_W'($countones(bulk_match)) : CI_W'(va_busy_q && va_found);

  xlate_satcnt #(.W(CNT_W), .IW(CI_W)) u_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hit_inc), .cnt_o(hit_cnt_o));
  xlate_satcnt #(.W(CNT_W), .IW(CI_W)) u_miss_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(miss_inc), .cnt_o(miss_cnt_o));
  xlate_satcnt #(.W(CNT_W), .IW(CI_W)) u_fill_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(fill_inc), .cnt_o(fill_cnt_o));
  xlate_satcnt #(.W(CNT_W), .IW(CI_W)) u_flush_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(flush_inc), .cnt_o(flush_cnt_o));
endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int VPN_W = 20,
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             lk_hit_o,
  input logic             fill_acc,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic             e0_v,
  input logic [VPN_W-1:0] e0_vpn,
  input logic             va_found,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] fill_cnt_o
);
  assert_stall_hit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !lk_hit_o);

  assert_fill_front_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_acc |=> (e0_v && e0_vpn == $past(fill_vpn_i)));

  assert_walk_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !va_found) |=> !busy_o);

  assert_hit_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cnt_o == $past(hit_cnt_o)) || (hit_cnt_o == $past(hit_cnt_o) + CNT_W'(1)));

  assert_fill_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_cnt_o == $past(fill_cnt_o)) || (fill_cnt_o == $past(fill_cnt_o) + CNT_W'(1)));
endmodule

bind xlate_cache xlate_cache_chk #(.VPN_W(VPN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .lk_hit_o(lk_hit_o),
  .fill_acc(fill_acc), .fill_vpn_i(fill_vpn_i), .e0_v(ent_q[0].v),
  .e0_vpn(ent_q[0].vpn), .va_found(va_found), .hit_cnt_o(hit_cnt_o),
  .fill_cnt_o(fill_cnt_o)
);

// File: tb/xlate_cache_test.sv
module xlate_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam logic [11:0] OFF = 12'h345;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic lk_valid = 0, lk_hyp = 0, lk_secure = 0, lk_debug = 0;
  logic [31:0] lk_va = '0;
  logic [7:0] lk_asid = '0, lk_vmid = '0;
  logic lk_hit, lk_global;
  logic [2:0] lk_idx;
  logic [31:0] lk_pa;
  logic [1:0] lk_el;
  logic fill = 0, fill_ns = 0, fill_hyp = 0, fill_glob = 0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic [7:0] fill_asid = '0, fill_vmid = '0;
  logic [1:0] fill_el = '0;
  logic inv_req = 0, inv_sec = 0, inv_hyp = 0;
  logic [1:0] inv_kind = '0;
  logic [7:0] inv_vmid = '0, inv_asid = '0;
  logic [19:0] inv_vpn = '0;
  logic busy;
  logic [CW-1:0] hit_cnt, miss_cnt, fill_cnt, flush_cnt;

  xlate_cache #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_asid_i(lk_asid), .lk_vmid_i(lk_vmid),
    .lk_hyp_i(lk_hyp), .lk_secure_i(lk_secure), .lk_debug_i(lk_debug),
    .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_pa_o(lk_pa), .lk_el_o(lk_el),
    .lk_global_o(lk_global),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn), .fill_asid_i(fill_asid),
    .fill_vmid_i(fill_vmid), .fill_ns_i(fill_ns), .fill_hyp_i(fill_hyp),
    .fill_global_i(fill_glob), .fill_el_i(fill_el),
    .inv_req_i(inv_req), .inv_kind_i(inv_kind), .inv_secure_i(inv_sec),
    .inv_vmid_i(inv_vmid), .inv_asid_i(inv_asid), .inv_vpn_i(inv_vpn), .inv_hyp_i(inv_hyp),
    .busy_o(busy), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt), .fill_cnt_o(fill_cnt),
    .flush_cnt_o(flush_cnt)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic r_hit;
  logic [2:0] r_idx;
  logic [31:0] r_pa;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [7:0] asid = 8'd1, input logic [7:0] vmid = 8'd1,
                         input logic ns = 1'b1, input logic glob = 1'b0);
    @(negedge clk);
    fill = 1; fill_vpn = vpn; fill_pfn = pfn; fill_asid = asid; fill_vmid = vmid;
    fill_ns = ns; fill_glob = glob; fill_hyp = 0; fill_el = 2'd1;
    @(posedge clk); #1 fill = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic dbg = 1'b1,
                      input logic [7:0] asid = 8'd1, input logic [7:0] vmid = 8'd1,
                      input logic sec = 1'b0, input logic hyp = 1'b0);
    @(negedge clk);
    lk_valid = 1; lk_va = {vpn, OFF}; lk_asid = asid; lk_vmid = vmid;
    lk_secure = sec; lk_hyp = hyp; lk_debug = dbg;
    #1 r_hit = lk_hit; r_idx = lk_idx; r_pa = lk_pa;
    @(posedge clk); #1 lk_valid = 0;
  endtask

  task automatic do_inv(input logic [1:0] kind, input logic sec, input logic [7:0] vmid,
                        input logic [7:0] asid = 8'd0, input logic [19:0] vpn = 20'd0);
    @(negedge clk);
    inv_req = 1; inv_kind = kind; inv_sec = sec; inv_vmid = vmid; inv_asid = asid;
    inv_vpn = vpn; inv_hyp = 0;
    @(posedge clk); #1 inv_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk); #1;
    check("R1 busy", busy, 0);
    check("R1 counters", {hit_cnt, miss_cnt, fill_cnt, flush_cnt}, 0);
    look(20'h0, 1'b1, 8'd0, 8'd0, 1'b1);
    check("R1 no valid slot", r_hit, 0);
  endtask

  task automatic t_order();
    do_reset();
    do_fill(20'h10, 20'hA0); do_fill(20'h11, 20'hB0); do_fill(20'h12, 20'hC0);
    look(20'h10);
    check("R2 hit", r_hit, 1);
    check("R4 oldest at slot 2", r_idx, 2);
    check("R2 pa", r_pa, {20'hA0, OFF});
    look(20'h12);
    check("R4 newest at slot 0", r_idx, 0);
    do_fill(20'h12, 20'hCC);
    look(20'h12);
    check("R3 lowest slot wins idx", r_idx, 0);
    check("R3 lowest slot wins pa", r_pa, {20'hCC, OFF});
  endtask

  task automatic t_promote();
    do_reset();
    do_fill(20'h10, 20'hA0); do_fill(20'h11, 20'hB0); do_fill(20'h12, 20'hC0);
    look(20'h11, 1'b0);
    look(20'h11);
    check("R6 slot1 hit keeps order", r_idx, 1);
    look(20'h10, 1'b1);
    look(20'h10);
    check("R6 debug hit keeps order", r_idx, 2);
    look(20'h10, 1'b0);
    look(20'h10); check("R5 promoted to 0", r_idx, 0);
    look(20'h12); check("R5 slot0 shifted to 1", r_idx, 1);
    look(20'h11); check("R5 slot1 shifted to 2", r_idx, 2);
  endtask

  task automatic t_evict();
    do_reset();
    for (int k = 0; k < 8; k++) do_fill(20'h20 + 20'(k), 20'h100 + 20'(k));
    look(20'h20); check("R4 full array last slot", r_idx, 7);
    do_fill(20'h28, 20'h108);
    look(20'h20); check("R4 last slot evicted", r_hit, 0);
    look(20'h21); check("R4 next moves to last", r_idx, 7);
  endtask

  task automatic t_match();
    do_reset();
    do_fill(20'h30, 20'h300, 8'd5, 8'd1, 1'b1, 1'b1);
    do_fill(20'h31, 20'h310, 8'd5, 8'd1, 1'b1, 1'b0);
    look(20'h30, 1'b1, 8'd9); check("R2 global any asid", r_hit, 1);
    look(20'h31, 1'b1, 8'd9); check("R2 nonglobal asid mismatch", r_hit, 0);
    look(20'h31, 1'b1, 8'd5); check("R2 nonglobal asid match", r_hit, 1);
    look(20'h31, 1'b1, 8'd5, 8'd1, 1'b1); check("R2 secure mismatch", r_hit, 0);
    look(20'h31, 1'b1, 8'd5, 8'd2); check("R2 vmid mismatch", r_hit, 0);
    look(20'h31, 1'b1, 8'd5, 8'd1, 1'b0, 1'b1); check("R2 hyp mismatch", r_hit, 0);
  endtask

  task automatic t_inv_all();
    do_reset();
    do_fill(20'h40, 20'h400, 8'd1, 8'd1, 1'b1);
    do_fill(20'h41, 20'h410, 8'd1, 8'd2, 1'b1);
    do_fill(20'h42, 20'h420, 8'd1, 8'd2, 1'b0);
    do_inv(2'd0, 1'b0, 8'd1);
    look(20'h40, 1'b1, 8'd1, 8'd1, 1'b0); check("R7 ns vmid match cleared", r_hit, 0);
    look(20'h41, 1'b1, 8'd1, 8'd2, 1'b0); check("R7 other vmid kept", r_hit, 1);
    look(20'h42, 1'b1, 8'd1, 8'd2, 1'b1); check("R7 secure entry kept", r_hit, 1);
    do_inv(2'd0, 1'b1, 8'd7);
    look(20'h42, 1'b1, 8'd1, 8'd2, 1'b1); check("R7 secure ignores vmid", r_hit, 0);
    look(20'h41, 1'b1, 8'd1, 8'd2, 1'b0); check("R7 ns kept by secure op", r_hit, 1);
  endtask

  task automatic t_inv_asid();
    do_reset();
    do_fill(20'h50, 20'h500, 8'd3, 8'd1);
    do_fill(20'h51, 20'h510, 8'd4, 8'd1);
    do_fill(20'h52, 20'h520, 8'd3, 8'd2);
    do_inv(2'd1, 1'b0, 8'd1, 8'd3);
    look(20'h50, 1'b1, 8'd3, 8'd1); check("R8 asid match cleared", r_hit, 0);
    look(20'h51, 1'b1, 8'd4, 8'd1); check("R8 other asid kept", r_hit, 1);
    look(20'h52, 1'b1, 8'd3, 8'd2); check("R8 other vmid kept", r_hit, 1);
  endtask

  task automatic t_inv_va();
    int n;
    do_reset();
    do_fill(20'h60, 20'h600, 8'd1);
    do_fill(20'h70, 20'h700, 8'd1);
    do_fill(20'h60, 20'h601, 8'd2);
    do_fill(20'h60, 20'h602, 8'd1);
    do_inv(2'd2, 1'b0, 8'd1, 8'd1, 20'h60);
    n = 0;
    @(negedge clk);
    lk_valid = 1; lk_va = {20'h70, OFF}; lk_asid = 1; lk_vmid = 1; lk_secure = 0;
    lk_hyp = 0; lk_debug = 1;
    fill = 1; fill_vpn = 20'h71; fill_pfn = 20'h710; fill_asid = 1; fill_vmid = 1;
    fill_ns = 1; fill_glob = 0;
    #1 check("R10 lookup stalled", lk_hit, 0);
    if (busy) n++;
    @(posedge clk); #1 lk_valid = 0; fill = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (busy) n++;
    end
    check("R9 busy k+1 cycles", 64'(n), 3);
    look(20'h60, 1'b1, 8'd1); check("R9 asid matches cleared", r_hit, 0);
    look(20'h60, 1'b1, 8'd2); check("R9 other asid kept", r_hit, 1);
    look(20'h70); check("R9 other va kept", r_hit, 1);
    look(20'h71); check("R10 fill ignored while busy", r_hit, 0);
    do_inv(2'd3, 1'b0, 8'd1, 8'd9, 20'h60);
    repeat (4) @(negedge clk);
    look(20'h60, 1'b1, 8'd2); check("R9 any-asid walk cleared", r_hit, 0);
  endtask

  task automatic t_prio();
    do_reset();
    do_fill(20'h80, 20'h800);
    @(negedge clk);
    lk_valid = 1; lk_va = {20'h80, OFF}; lk_asid = 1; lk_vmid = 1; lk_secure = 0;
    lk_hyp = 0; lk_debug = 0;
    fill = 1; fill_vpn = 20'h81; fill_pfn = 20'h810; fill_asid = 1; fill_vmid = 1;
    fill_ns = 1; fill_glob = 0;
    #1 check("R11 lookup loses to fill", lk_hit, 0);
    @(posedge clk); #1 lk_valid = 0; fill = 0;
    look(20'h80); check("R11 fill applied", r_idx, 1);
    @(negedge clk);
    inv_req = 1; inv_kind = 2'd0; inv_sec = 0; inv_vmid = 1;
    fill = 1; fill_vpn = 20'h82;
    @(posedge clk); #1 inv_req = 0; fill = 0;
    look(20'h82); check("R11 fill loses to invalidate", r_hit, 0);
    look(20'h81); check("R11 invalidate applied", r_hit, 0);
  endtask

  task automatic t_cnt();
    do_reset();
    do_fill(20'h90, 20'h900); do_fill(20'h91, 20'h910); do_fill(20'h92, 20'h920);
    look(20'h90, 1'b0); look(20'h91, 1'b0); look(20'h99, 1'b0); look(20'h92, 1'b1);
    @(negedge clk);
    check("R12 fill count", fill_cnt, 3);
    check("R12 hit count", hit_cnt, 2);
    check("R12 miss count", miss_cnt, 1);
    do_inv(2'd0, 1'b0, 8'd1);
    @(negedge clk);
    check("R12 flush count", flush_cnt, 3);
    for (int k = 0; k < 20; k++) do_fill(20'hA0 + 20'(k), 20'h0);
    @(negedge clk);
    check("R12 fill saturates", fill_cnt, 15);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_promote();
    t_evict();
    t_match();
    t_inv_all();
    t_inv_asid();
    t_inv_va();
    t_prio();
    t_cnt();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule